// File: doc/BRIEF.md
# Endpoint-Fit Converter Linearity Calculator

This block measures the static linearity of an N-bit analog-to-digital converter from a table of its measured transition voltages. It accepts the 2^N−1 transition voltages over a valid/ready stream, lowest transition first, and stores them in an internal table. Once the table is complete it derives the step size from the two end transitions. A converter with 2^N codes has 2^N−1 transitions and 2^N−2 steps between its outermost transitions. From that step size it derives the offset error and, for every transition index, the differential and integral nonlinearity in units of that step.

The step size comes from the endpoints, so the ideal line passes exactly through the first and last measured transitions. The integral nonlinearity is then zero at both ends, and the differential values sum to zero. Every quotient comes from one shared restoring divider that runs one bit per cycle. One result record per transition index leaves the block in ascending order under backpressure, then one summary record that carries the step size and the offset. If the last transition is not above the first, the block flags an error and emits nothing.

The control is one state machine. Its states are named as follows. LOAD takes samples. CHECK tests the span. FAIL raises the error flag. FETCH and LATCH read one table entry. DNL_GO/DNL_RUN and INL_GO/INL_RUN run the two divisions for each record. EMIT offers the record. LSB_GO/LSB_RUN and OFS_GO/OFS_RUN compute the summary values. SUMMARY offers the final record.

The transitions are as follows:
- LOAD→CHECK after the last sample.
- CHECK→FAIL when the span is not positive, otherwise CHECK→FETCH.
- FAIL→LOAD.
- FETCH→LATCH→DNL_GO→DNL_RUN.
- DNL_RUN→INL_GO when the divider finishes, then INL_GO→INL_RUN.
- INL_RUN→EMIT when the divider finishes.
- EMIT→FETCH on acceptance of a record that is not the last.
- EMIT→LSB_GO on acceptance of the last record.
- LSB_GO→LSB_RUN→OFS_GO→OFS_RUN→SUMMARY.
- SUMMARY→LOAD on acceptance.

Top module: `lin_endpoint_fit`

## Requirements
- R1: `in_ready` is high only while the table is being collected. Exactly 2^N−1 samples (unsigned Q16.16) are accepted, index 0 first. No result is offered before the last sample has been accepted.
- R2: The summary `out_lsb` equals S/(2^N−2) rounded to nearest in unsigned Q16.16, where S = V[last] − V[0].
- R3: The summary `out_offset` is signed Q16.16 and equals V[0] − round(S/(2·(2^N−2))), so the ideal first transition sits half a step above zero.
- R4: For index k≥1, `out_dnl` equals ((V[k]−V[k−1])·(2^N−2) − S)/S in signed Q8.16. For index 0 it is zero.
- R5: `out_inl` equals ((V[k]−V[0])·(2^N−2) − k·S)/S in signed Q8.16. It is exactly zero at index 0 and at index 2^N−2.
- R6: When no value saturates, the sum of the DNL values is within (2^N−2)/2 units of the last place of zero.
- R7: Quotients round half away from zero. Values beyond ±(2^23−1) clamp to that bound with their sign kept.
- R8: The records carry `out_kind`=0 with `out_code` running 0,1,…,2^N−2 in order. One record with `out_kind`=1 follows them.
- R9: While `out_valid` is high and `out_ready` is low, the offered record does not change and stays valid.
- R10: `out_done` is high exactly while the summary record is offered.
- R11: If V[last] ≤ V[0], `out_err` is high for one cycle, two cycles after the last sample is accepted. No record follows, and the block returns to collecting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Transition sample offered |
| in_ready | output | 1 | Block collects samples |
| in_volt | input | 32 | Transition voltage, unsigned Q16.16 |
| out_valid | output | 1 | Record offered |
| out_ready | input | 1 | Consumer takes the record |
| out_kind | output | 1 | 0 = per-index record, 1 = summary |
| out_code | output | N | Transition index of the record |
| out_dnl | output | 24 | DNL, signed Q8.16 |
| out_inl | output | 24 | INL, signed Q8.16 |
| out_lsb | output | 32 | Step size, unsigned Q16.16 (summary) |
| out_offset | output | 33 | Offset error, signed Q16.16 (summary) |
| out_done | output | 1 | High with the summary record |
| out_err | output | 1 | One-cycle error pulse for a non-positive span |

## Verification
The error flag is the only result due at a fixed cycle. It is checked at the second falling edge after the edge that takes the last sample, and the first falling edge and the third are checked to show it low. Records arrive after the divider's 64-cycle passes, and their timing also depends on backpressure. The bench therefore ties each check to the handshake: it samples at the falling edge, and a record counts as taken when `out_valid` and the `out_ready` that the bench just drove are both high. While the consumer stalls, the bench checks at every falling edge that the held record is unchanged.

// File: rtl/lin_pkg.sv
package lin_pkg;
    localparam int VOLT_W = 32;
    localparam int FRAC_W = 16;
    localparam int RES_W  = 24;
    localparam int NUM_W  = 64;

    typedef enum logic [3:0] {
        ST_LOAD, ST_CHECK, ST_FAIL, ST_FETCH, ST_LATCH,
        ST_DNL_GO, ST_DNL_RUN, ST_INL_GO, ST_INL_RUN, ST_EMIT,
        ST_LSB_GO, ST_LSB_RUN, ST_OFS_GO, ST_OFS_RUN, ST_SUMMARY
    } lin_state_t;
endpackage

// File: rtl/lin_table_ram.sv
module lin_table_ram #(
    parameter int DEPTH = 15,
    parameter int AW    = 4,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/lin_seq_div.sv
module lin_seq_div #(
    parameter int NW = 64,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          busy,
    output logic          done,
    output logic [NW-1:0] quot
);
    localparam int CW = $clog2(NW + 1);

    logic [DW-1:0] rem_q;
    logic [DW-1:0] den_q;
    logic [CW-1:0] cnt_q;
    logic [DW:0]   trial;

    assign trial = {rem_q, quot[NW-1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            quot  <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_q <= '0;
                den_q <= den;
                quot  <= num;
                cnt_q <= CW'(NW);
                busy  <= 1'b1;
            end else if (busy) begin
                if (trial >= {1'b0, den_q}) begin
                    rem_q <= DW'(trial - {1'b0, den_q});
                    quot  <= {quot[NW-2:0], 1'b1};
                end else begin
                    rem_q <= trial[DW-1:0];
                    quot  <= {quot[NW-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R7: a new division never begins on top of a running one
    p_div_start_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    // R7: completion ends the busy phase
    p_div_done_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: rtl/lin_endpoint_fit.sv
module lin_endpoint_fit
    import lin_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [VOLT_W-1:0]    in_volt,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic                 out_kind,
    output logic [N-1:0]         out_code,
    output logic [RES_W-1:0]     out_dnl,
    output logic [RES_W-1:0]     out_inl,
    output logic [VOLT_W-1:0]    out_lsb,
    output logic [VOLT_W:0]      out_offset,
    output logic                 out_done,
    output logic                 out_err
);
    localparam int NTR = (1 << N) - 1;
    localparam int TM1 = NTR - 1;
    localparam logic signed [NUM_W-1:0] TM1_S = NUM_W'(TM1);
    localparam logic [NUM_W-1:0] RES_MAX = NUM_W'((1 << (RES_W - 1)) - 1);

    lin_state_t st_q, st_d;

    logic [N-1:0]        ld_idx, k_q;
    logic [VOLT_W-1:0]   v0_q, vl_q, span_q, cur_q, prev_q, rd_data;
    logic [RES_W-1:0]    dnl_q, inl_q;
    logic [VOLT_W-1:0]   lsb_q;
    logic [VOLT_W:0]     ofs_q;
    logic                take;

    logic                div_start, div_busy, div_done;
    logic [NUM_W-1:0]    div_num, div_q;
    logic [VOLT_W-1:0]   div_den;

    logic signed [NUM_W-1:0] cur_s, prev_s, v0_s, span_s, k_s;
    logic signed [NUM_W-1:0] dnl_raw, inl_raw;

    function automatic logic [NUM_W-1:0] mag_of(input logic signed [NUM_W-1:0] x);
        return (x < 0) ? NUM_W'(-x) : NUM_W'(x);
    endfunction

    function automatic logic [RES_W-1:0] clamp_sign(input logic [NUM_W-1:0] q,
                                                    input logic neg);
        logic [RES_W-1:0] m;
        m = (q > RES_MAX) ? RES_W'(RES_MAX) : q[RES_W-1:0];
        return neg ? RES_W'(-m) : m;
    endfunction

    assign take = in_valid && in_ready;

    lin_table_ram #(.DEPTH(NTR), .AW(N), .DW(VOLT_W)) u_tab (
        .clk   (clk),
        .we    (take),
        .waddr (ld_idx),
        .wdata (in_volt),
        .raddr (k_q),
        .rdata (rd_data)
    );

    lin_seq_div #(.NW(NUM_W), .DW(VOLT_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .busy  (div_busy),
        .done  (div_done),
        .quot  (div_q)
    );

    assign cur_s  = $signed({{(NUM_W-VOLT_W){1'b0}}, cur_q});
    assign prev_s = $signed({{(NUM_W-VOLT_W){1'b0}}, prev_q});
    assign v0_s   = $signed({{(NUM_W-VOLT_W){1'b0}}, v0_q});
    assign span_s = $signed({{(NUM_W-VOLT_W){1'b0}}, span_q});
    assign k_s    = $signed({{(NUM_W-N){1'b0}}, k_q});

    assign dnl_raw = (k_q == '0) ? '0 : (cur_s - prev_s) * TM1_S - span_s;
    assign inl_raw = (cur_s - v0_s) * TM1_S - k_s * span_s;

    // divider operands, chosen by the state
    always_comb begin
        div_num   = '0;
        div_den   = span_q;
        div_start = 1'b0;
        unique case (st_q)
            ST_DNL_GO: begin
                div_start = 1'b1;
                div_num   = (mag_of(dnl_raw) << FRAC_W) + NUM_W'(span_q >> 1);
            end
            ST_INL_GO: begin
                div_start = 1'b1;
                div_num   = (mag_of(inl_raw) << FRAC_W) + NUM_W'(span_q >> 1);
            end
            ST_LSB_GO: begin
                div_start = 1'b1;
                div_num   = NUM_W'(span_q) + NUM_W'(TM1 / 2);
                div_den   = VOLT_W'(TM1);
            end
            ST_OFS_GO: begin
                div_start = 1'b1;
                div_num   = NUM_W'(span_q) + NUM_W'(TM1);
                div_den   = VOLT_W'(2 * TM1);
            end
            default: ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_LOAD;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_LOAD:    if (take && ld_idx == N'(TM1)) st_d = ST_CHECK;
            ST_CHECK:   st_d = (vl_q > v0_q) ? ST_FETCH : ST_FAIL;
            ST_FAIL:    st_d = ST_LOAD;
            ST_FETCH:   st_d = ST_LATCH;
            ST_LATCH:   st_d = ST_DNL_GO;
            ST_DNL_GO:  st_d = ST_DNL_RUN;
            ST_DNL_RUN: if (div_done) st_d = ST_INL_GO;
            ST_INL_GO:  st_d = ST_INL_RUN;
            ST_INL_RUN: if (div_done) st_d = ST_EMIT;
            ST_EMIT:    if (out_ready) st_d = (k_q == N'(TM1)) ? ST_LSB_GO : ST_FETCH;
            ST_LSB_GO:  st_d = ST_LSB_RUN;
            ST_LSB_RUN: if (div_done) st_d = ST_OFS_GO;
            ST_OFS_GO:  st_d = ST_OFS_RUN;
            ST_OFS_RUN: if (div_done) st_d = ST_SUMMARY;
            ST_SUMMARY: if (out_ready) st_d = ST_LOAD;
            default:    st_d = ST_LOAD;
        endcase
    end

    // outputs
    always_comb begin
        in_ready   = (st_q == ST_LOAD);
        out_valid  = (st_q == ST_EMIT) || (st_q == ST_SUMMARY);
        out_kind   = (st_q == ST_SUMMARY);
        out_done   = (st_q == ST_SUMMARY);
        out_err    = (st_q == ST_FAIL);
        out_code   = k_q;
        out_dnl    = dnl_q;
        out_inl    = inl_q;
        out_lsb    = lsb_q;
        out_offset = ofs_q;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_idx <= '0;
            k_q    <= '0;
            v0_q   <= '0;
            vl_q   <= '0;
            span_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
            dnl_q  <= '0;
            inl_q  <= '0;
            lsb_q  <= '0;
            ofs_q  <= '0;
        end else begin
            unique case (st_q)
                ST_LOAD: if (take) begin
                    if (ld_idx == '0) v0_q <= in_volt;
                    if (ld_idx == N'(TM1)) begin
                        vl_q   <= in_volt;
                        ld_idx <= '0;
                    end else begin
                        ld_idx <= ld_idx + 1'b1;
                    end
                end
                ST_CHECK: begin
                    span_q <= vl_q - v0_q;
                    k_q    <= '0;
                    prev_q <= v0_q;
                end
                ST_LATCH:   cur_q <= rd_data;
                ST_DNL_RUN: if (div_done) dnl_q <= clamp_sign(div_q, dnl_raw < 0);
                ST_INL_RUN: if (div_done) inl_q <= clamp_sign(div_q, inl_raw < 0);
                ST_EMIT: if (out_ready) begin
                    prev_q <= cur_q;
                    if (k_q != N'(TM1)) k_q <= k_q + 1'b1;
                end
                ST_LSB_RUN: if (div_done) lsb_q <= div_q[VOLT_W-1:0];
                ST_OFS_RUN: if (div_done)
                    ofs_q <= {1'b0, v0_q} - {1'b0, div_q[VOLT_W-1:0]};
                default: ;
            endcase
        end
    end

    // R1: collection and result phases never overlap
    p_load_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);
    // R4: first index has zero DNL
    p_dnl_first_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_kind && out_code == '0) |-> out_dnl == '0);
    // R5: INL pinned to zero at both end indices
    p_inl_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_kind && (out_code == '0 || out_code == N'(TM1)))
            |-> out_inl == '0);
    // R9: a stalled record holds
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) &&
            $stable(out_code) && $stable(out_dnl) && $stable(out_inl)));
    // R10: done only travels with the summary
    p_done_summary_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> (out_valid && out_kind));
    // R11: error pulse is single and silent
    p_err_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |=> (!out_err && in_ready && !out_valid));
endmodule

// File: tb/sim_lin_endpoint_fit.sv
`timescale 1ns/1ps
module sim_lin_endpoint_fit;
    localparam int N   = 4;
    localparam int NTR = (1 << N) - 1;
    localparam int TM1 = NTR - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_volt = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        out_kind;
    logic [N-1:0] out_code;
    logic [23:0] out_dnl, out_inl;
    logic [31:0] out_lsb;
    logic [32:0] out_offset;
    logic        out_done, out_err;

    int checks = 0;
    int fails  = 0;
    longint tv [NTR];

    always #2 clk = ~clk;

    lin_endpoint_fit #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_volt(in_volt), .out_valid(out_valid), .out_ready(out_ready),
        .out_kind(out_kind), .out_code(out_code), .out_dnl(out_dnl),
        .out_inl(out_inl), .out_lsb(out_lsb), .out_offset(out_offset),
        .out_done(out_done), .out_err(out_err)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint rdiv(input longint raw, input longint span);
        longint m, q;
        m = (raw < 0) ? -raw : raw;
        q = (m * 65536 + span / 2) / span;
        if (q > 8388607) q = 8388607;
        return (raw < 0) ? -q : q;
    endfunction

    function automatic longint exp_dnl(input int k);
        longint s = tv[TM1] - tv[0];
        if (k == 0) return rdiv(0, s);
        return rdiv((tv[k] - tv[k-1]) * TM1 - s, s);
    endfunction

    function automatic longint exp_inl(input int k);
        longint s = tv[TM1] - tv[0];
        return rdiv((tv[k] - tv[0]) * TM1 - longint'(k) * s, s);
    endfunction

    task automatic feed();
        int idx = 0;
        while (idx < NTR) begin
            @(negedge clk);
            in_valid = ($urandom % 4) != 0;
            in_volt  = 32'(tv[idx]);
            if (in_valid && !in_ready)
                chk(1'b0, "R1 ready during load", in_ready, 1);
            if (in_valid && in_ready) idx++;
        end
    endtask

    task automatic run_table();
        bit ok_exp = tv[TM1] > tv[0];
        int kx = 0;
        bit held = 0, sat = 0, got_sum = 0;
        logic [23:0] h_dnl, h_inl;
        logic [N-1:0] h_code;
        logic h_kind;
        longint dsum = 0;
        longint s = tv[TM1] - tv[0];
        feed();
        if (!ok_exp) begin
            @(negedge clk); in_valid = 1'b0;
            chk(!out_err && !out_valid, "R11 err early", out_err, 0);
            @(negedge clk);
            chk(out_err == 1'b1 && !out_valid, "R11 err pulse", out_err, 1);
            @(negedge clk);
            chk(!out_err && in_ready && !out_valid, "R11 back to load", in_ready, 1);
            return;
        end
        for (int cyc = 0; cyc < 20000 && !got_sum; cyc++) begin
            @(negedge clk);
            in_valid = 1'b0;
            if (held)
                chk(out_valid && out_kind == h_kind && out_code == h_code &&
                    out_dnl == h_dnl && out_inl == h_inl, "R9 hold", out_dnl, h_dnl);
            chk(out_done == (out_valid && out_kind), "R10 done", out_done, out_valid && out_kind);
            if (out_valid) chk(!in_ready, "R1 no overlap", in_ready, 0);
            out_ready = ($urandom % 3) != 0;
            held = out_valid && !out_ready;
            h_dnl = out_dnl; h_inl = out_inl; h_code = out_code; h_kind = out_kind;
            if (out_valid && out_ready) begin
                if (kx < NTR) begin
                    longint ed = exp_dnl(kx), ei = exp_inl(kx);
                    chk(!out_kind && out_code == N'(kx), "R8 order", out_code, kx);
                    chk(longint'($signed(out_dnl)) == ed, "R4 dnl", $signed(out_dnl), ed);
                    chk(longint'($signed(out_inl)) == ei, "R5 inl", $signed(out_inl), ei);
                    if (ed == 8388607 || ed == -8388607 || ei == 8388607 || ei == -8388607) sat = 1;
                    if (kx == 0 || kx == TM1)
                        chk(out_inl == '0, "R5 inl end zero", $signed(out_inl), 0);
                    dsum += longint'($signed(out_dnl));
                    kx++;
                end else begin
                    longint el = (s + TM1 / 2) / TM1;
                    longint eo = tv[0] - (s + TM1) / (2 * TM1);
                    chk(out_kind == 1'b1, "R8 summary kind", out_kind, 1);
                    chk(longint'(out_lsb) == el, "R2 lsb", out_lsb, el);
                    chk(longint'($signed(out_offset)) == eo, "R3 offset", $signed(out_offset), eo);
                    if (!sat)
                        chk(dsum <= TM1 / 2 && dsum >= -(TM1 / 2), "R6 dnl sum", dsum, 0);
                    else
                        chk(sat, "R7 saturation seen", sat, 1);
                    got_sum = 1;
                end
            end
        end
        chk(got_sum, "R8 summary arrived", got_sum, 1);
        @(negedge clk); out_ready = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin @(posedge clk); cyc++; end
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(in_ready && !out_valid && !out_err && !out_done, "R1 reset state", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready && !out_valid, "R1 after reset", in_ready, 1);

        // ideal ramp: zero DNL/INL, zero offset, unit step (R2 R3 R4 R5)
        for (int k = 0; k < NTR; k++) tv[k] = 32768 + longint'(k) * 65536;
        run_table();

        // all equal transitions: error (R11)
        for (int k = 0; k < NTR; k++) tv[k] = 500000;
        run_table();

        // monotone jittered tables (R4 R5 R6)
        for (int r = 0; r < 3; r++) begin
            tv[0] = 10000 + ($urandom % 40000);
            for (int k = 1; k < NTR; k++)
                tv[k] = tv[k-1] + 65536 + longint'($urandom % 40001) - 20000;
            run_table();
        end

        // last below first: error (R11)
        for (int k = 0; k < NTR; k++) tv[k] = 900000 - longint'(k) * 1000;
        run_table();

        // non-monotone random (R4 R7)
        for (int r = 0; r < 2; r++) begin
            tv[0] = 1048576;
            for (int k = 1; k < NTR; k++)
                tv[k] = tv[k-1] + longint'($urandom % 131072) - 30000;
            run_table();
        end

        // huge single step, tiny span: saturation (R7)
        tv[0] = 0; tv[1] = 64'h8000_0000;
        for (int k = 2; k < NTR; k++) tv[k] = k;
        run_table();

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule